// File: doc/BRIEF.md
# Write-Busy Status Read Formatter

This block decides which byte a nonvolatile memory presents on its data bus while an internal erase or program operation is running. Before an operation starts, the host loads a byte (address and data) and the block keeps the most recent one. A start pulse launches the internal write timer. That timer is a counter, and its duration is a parameter.

While the timer runs, reads of the loaded address return that byte with bit 7 inverted and bit 6 replaced by a flip bit. The flip bit changes on every read. Reads of any other address return the array's data with the same flip bit on bit 6. Once the timer expires, every read returns the array's data unchanged, so two successive reads of one location agree.

Software can detect completion in three ways:
- wait for the polled bit 7 to match the byte it wrote;
- wait for bit 6 to stop changing;
- compare two consecutive reads.

A read is one high period of the read enable. The result is sampled at the start of that period and held for the whole of it. Cell programming is outside this block; the true array contents arrive on an input.

Top module: `wip_status_reader`

## Requirements
- R1: While reset is asserted, and until the first read after reset, `rd_data` is 0 and `busy` is 0.
- R2: A `wr_go` pulse accepted while `busy` is low starts an operation. From the following clock, `busy` is high for exactly `WR_CYCLES` cycles. A `wr_go` while `busy` is high is ignored. Erase and program use the same start pulse and report status identically.
- R3: `ld_en` while `busy` is low records `ld_addr` and `ld_data` as the loaded byte, and the latest load wins. `ld_en` while `busy` is high leaves the recorded byte unchanged.
- R4: A read of the loaded address that starts while `busy` is high returns bit 7 (the top bit of `rd_data`) as the complement of bit 7 of the loaded data.
- R5: In such a read, bits 5 to 0 are the loaded data's own bits 5 to 0.
- R6: The flip bit is cleared when an operation starts. Every read that starts while `busy` is high returns it on bit 6 and then inverts it, so the first such read gives 0, the next 1, and so on.
- R7: A read of any other address that starts while `busy` is high returns `arr_data` with bit 6 replaced by the flip bit.
- R8: A read that starts while `busy` is low returns `arr_data` unmodified, and bit 6 no longer changes, so repeated reads of one address agree.
- R9: `rd_data` takes its new value on the clock after the rising edge of `rd_en` and holds it until the next rising edge, even if `busy` falls during the read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ld_en | input | 1 | Byte-load strobe |
| ld_addr | input | ADDR_W | Address of the byte being loaded |
| ld_data | input | DATA_W | Data of the byte being loaded |
| wr_go | input | 1 | Starts an erase or program operation |
| rd_en | input | 1 | Read enable; each high period is one read |
| rd_addr | input | ADDR_W | Read address |
| arr_data | input | DATA_W | True array contents at `rd_addr` |
| rd_data | output | DATA_W | Byte presented on the bus |
| busy | output | 1 | High while the write timer runs |

## Verification
The assertions check several rules on every cycle:
- `busy` rises only after a start pulse.
- The loaded byte cannot change while busy.
- The output changes only on the clock after a read begins.
- A polled read inverts bit 7.
- An idle read passes the array data straight through.

Only the bench's scenarios can show the timer's exact length and the ignored second start. The same holds for the alternating sequence of the flip bit and its clearing at the next operation, and for a read whose value stays fixed while `busy` falls during it.

// File: rtl/wsr_pkg.sv
package wsr_pkg;
  typedef enum logic [1:0] {
    FMT_PLAIN = 2'd0,
    FMT_POLL  = 2'd1,
    FMT_FLIP  = 2'd2
  } rd_fmt_e;
endpackage

// File: rtl/wsr_rst_sync.sv
module wsr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sh_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sh_q[g] <= 1'b0;
        else         sh_q[g] <= 1'b1;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sh_q[g] <= 1'b0;
        else         sh_q[g] <= sh_q[g-1];
      end
    end
  end

  assign srst_n = sh_q[STAGES-1];
endmodule

// File: rtl/wsr_write_timer.sv
module wsr_write_timer #(
  parameter int WR_CYCLES = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  output logic busy,
  output logic start
);
  localparam int CNT_W = $clog2(WR_CYCLES + 1);

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign start = go & ~busy_q;
  assign busy  = busy_q;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    cnt_en = start | busy_q;
    if (start) begin
      busy_d = 1'b1;
      cnt_d  = CNT_W'(WR_CYCLES - 1);
    end else if (busy_q) begin
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (cnt_en) begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/wsr_load_latch.sv
module wsr_load_latch #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic              blocked,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [DATA_W-1:0] ld_data,
  output logic [ADDR_W-1:0] ref_addr,
  output logic [DATA_W-1:0] ref_data
);
  logic cap_en;

  assign cap_en = ld_en & ~blocked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_addr <= '0;
      ref_data <= '0;
    end else if (cap_en) begin
      ref_addr <= ld_addr;
      ref_data <= ld_data;
    end
  end
endmodule

// File: rtl/wsr_read_fmt.sv
module wsr_read_fmt
  import wsr_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] arr_data,
  input  logic              busy,
  input  logic              start,
  input  logic [ADDR_W-1:0] ref_addr,
  input  logic [DATA_W-1:0] ref_data,
  output logic [DATA_W-1:0] rd_data
);
  localparam int POLL_BIT = DATA_W - 1;
  localparam int FLIP_BIT = DATA_W - 2;

  logic              rd_en_q;
  logic              rise;
  logic              flip_q, flip_d;
  logic              flip_en;
  rd_fmt_e           fmt;
  logic [DATA_W-1:0] word;
  logic [DATA_W-1:0] out_q;

  assign rise    = rd_en & ~rd_en_q;
  assign flip_en = start | (rise & busy);

  always_comb begin
    if (!busy)                   fmt = FMT_PLAIN;
    else if (rd_addr == ref_addr) fmt = FMT_POLL;
    else                         fmt = FMT_FLIP;
  end

  always_comb begin
    word = arr_data;
    case (fmt)
      FMT_POLL: begin
        word           = ref_data;
        word[POLL_BIT] = ~ref_data[POLL_BIT];
        word[FLIP_BIT] = flip_q;
      end
      FMT_FLIP: word[FLIP_BIT] = flip_q;
      default:  word = arr_data;
    endcase
  end

  always_comb begin
    if (start) flip_d = 1'b0;
    else       flip_d = ~flip_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_en_q <= 1'b0;
    else        rd_en_q <= rd_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flip_q <= 1'b0;
    else if (flip_en) flip_q <= flip_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    out_q <= '0;
    else if (rise) out_q <= word;
  end

  assign rd_data = out_q;
endmodule

// File: rtl/wip_status_reader.sv
module wip_status_reader #(
  parameter int ADDR_W      = 19,
  parameter int DATA_W      = 8,
  parameter int WR_CYCLES   = 40,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              wr_go,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] arr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy
);
  logic              srst_n;
  logic              start;
  logic [ADDR_W-1:0] ref_addr;
  logic [DATA_W-1:0] ref_data;

  wsr_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(srst_n)
  );

  wsr_write_timer #(.WR_CYCLES(WR_CYCLES)) u_timer (
    .clk(clk), .rst_n(srst_n), .go(wr_go), .busy(busy), .start(start)
  );

  wsr_load_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_latch (
    .clk(clk), .rst_n(srst_n), .ld_en(ld_en), .blocked(busy),
    .ld_addr(ld_addr), .ld_data(ld_data),
    .ref_addr(ref_addr), .ref_data(ref_data)
  );

  wsr_read_fmt #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fmt (
    .clk(clk), .rst_n(srst_n), .rd_en(rd_en), .rd_addr(rd_addr),
    .arr_data(arr_data), .busy(busy), .start(start),
    .ref_addr(ref_addr), .ref_data(ref_data), .rd_data(rd_data)
  );
endmodule

// File: rtl/wip_status_reader_chk.sv
module wip_status_reader_chk #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_go,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [DATA_W-1:0] arr_data,
  input logic [DATA_W-1:0] rd_data,
  input logic              busy,
  input logic [ADDR_W-1:0] ref_addr,
  input logic [DATA_W-1:0] ref_data
);
  assert_busy_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wr_go));

  assert_ref_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(ref_addr) && $stable(ref_data)));

  assert_poll_invert_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !$past(rd_en) && busy && rd_addr == ref_addr)
      |=> rd_data[DATA_W-1] == ~$past(ref_data[DATA_W-1]));

  assert_idle_plain_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !$past(rd_en) && !busy) |=> rd_data == $past(arr_data));

  assert_out_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_data) |-> ($past(rd_en) && !$past(rd_en, 2)));
endmodule

bind wip_status_reader wip_status_reader_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_go(wr_go), .rd_en(rd_en), .rd_addr(rd_addr),
  .arr_data(arr_data), .rd_data(rd_data), .busy(busy),
  .ref_addr(ref_addr), .ref_data(ref_data)
);

// File: tb/wip_status_reader_bench.sv
`timescale 1ns/1ps
module wip_status_reader_bench;
  localparam int AW  = 19;
  localparam int DW  = 8;
  localparam int WRC = 30;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ld_en, wr_go, rd_en;
  logic [AW-1:0] ld_addr, rd_addr;
  logic [DW-1:0] ld_data, arr_data;
  logic [DW-1:0] rd_data;
  logic          busy;

  always #2.5 clk = ~clk;

  function automatic logic [DW-1:0] arr_of(input logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction
  assign arr_data = arr_of(rd_addr);

  wip_status_reader #(.ADDR_W(AW), .DATA_W(DW), .WR_CYCLES(WRC)) u_wip_status_reader (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
    .wr_go(wr_go), .rd_en(rd_en), .rd_addr(rd_addr), .arr_data(arr_data),
    .rd_data(rd_data), .busy(busy)
  );

  // behavioural reference
  integer        rel_cnt, remain;
  logic          m_busy, m_flip, m_prev_rd;
  logic [AW-1:0] m_addr;
  logic [DW-1:0] m_data, m_out;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rel_cnt = 0; remain = 0; m_busy = 0; m_flip = 0; m_prev_rd = 0;
      m_addr = '0; m_data = '0; m_out = '0;
    end else if (rel_cnt < 2) begin
      rel_cnt = rel_cnt + 1;
    end else begin
      logic was_busy;
      was_busy = m_busy;
      if (rd_en && !m_prev_rd) begin
        if (!was_busy) m_out = arr_of(rd_addr);
        else begin
          if (rd_addr == m_addr) m_out = {~m_data[7], m_flip, m_data[5:0]};
          else                   m_out = {arr_of(rd_addr)[7], m_flip, arr_of(rd_addr)[5:0]};
          m_flip = ~m_flip;
        end
      end
      if (ld_en && !was_busy) begin m_addr = ld_addr; m_data = ld_data; end
      if (!was_busy && wr_go) begin m_busy = 1; remain = WRC - 1; m_flip = 0; end
      else if (was_busy) begin
        if (remain == 0) m_busy = 0; else remain = remain - 1;
      end
      m_prev_rd = rd_en;
    end
  end

  integer vecs = 0, fails = 0, cyc = 0;
  string  tag = "R1";
  logic   done = 1'b0;

  always @(negedge clk) if (!done) begin
    vecs = vecs + 1;
    if (rd_data !== m_out || busy !== m_busy) begin
      fails = fails + 1;
      $display("FAIL %s rd_data=%h exp %h busy=%b exp %b", tag, rd_data, m_out, busy, m_busy);
    end
  end

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc > 20000 && !done) begin
      fails = fails + 1;
      done = 1'b1;
      $display("FAIL watchdog expired rd_data=%h exp %h", rd_data, m_out);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_read(input logic [AW-1:0] a, input int hold);
    @(negedge clk); rd_en = 1'b1; rd_addr = a;
    idle(hold);
    rd_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_load(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk); ld_en = 1'b1; ld_addr = a; ld_data = d;
    @(negedge clk); ld_en = 1'b0;
  endtask

  task automatic pulse_go;
    @(negedge clk); wr_go = 1'b1;
    @(negedge clk); wr_go = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; ld_en = 0; wr_go = 0; rd_en = 0;
    ld_addr = '0; ld_data = '0; rd_addr = '0;
    tag = "R1"; idle(4);
    rst_n = 1'b1; idle(5);
    tag = "R8"; do_read(19'h00123, 2); do_read(19'h00123, 1); do_read(19'h00456, 3);
    tag = "R3"; do_load(19'h00777, 8'h12); do_load(19'h01C40, 8'hC5);
    tag = "R2"; pulse_go();
    tag = "R4/R5/R6";
    do_read(19'h01C40, 1); do_read(19'h01C40, 1); do_read(19'h01C40, 2);
    tag = "R7"; do_read(19'h00456, 1); do_read(19'h00456, 1);
    tag = "R2/R3"; pulse_go(); do_load(19'h00777, 8'h00);
    tag = "R4/R6"; do_read(19'h01C40, 1);
    tag = "R9"; do_read(19'h01C40, 30);
    tag = "R8"; do_read(19'h01C40, 1); do_read(19'h01C40, 1); do_read(19'h00456, 1);
    tag = "R3"; do_load(19'h00055, 8'h3A);
    tag = "R6"; pulse_go(); do_read(19'h00055, 1); do_read(19'h00055, 1);
    do_read(19'h00123, 1);
    tag = "R2"; idle(WRC + 2);
    tag = "R8"; do_read(19'h00055, 1); do_read(19'h00055, 1);
    idle(2);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule